// File: doc/BRIEF.md
# Register Scoreboard and Wakeup Unit

This block keeps track of which physical registers hold a final value and which issue-window entries have all of their source operands available. Every physical register has one scoreboard bit; the physical register space is the sum of the integer and the floating-point register counts. Each issue-window slot holds up to two source tags, each with its own operand-ready flag, and drives one bit of a ready vector that an issue selector consumes.

Dispatch writes a slot with its source tags, the rename stage's view of whether each source is ready, and an optional destination tag. The destination's scoreboard bit is cleared because the new instruction becomes its producer. A source that dispatch flags as not ready is checked against the scoreboard and against the completion port in the same cycle, so a value that arrived while the instruction was in flight is not missed. A completion port broadcasts one finished tag per cycle. It wakes every waiting operand that names that tag, sets the tag's scoreboard bit, and reports how many slots were woken. A squash mask frees slots so that later completions cannot touch them. Tags at or above the physical register count fall outside tracking.

Each slot runs a three-state machine: FREE (empty), WAIT (at least one source pending) and READY (all sources available). The transitions are: DISPATCH_ALL_READY (FREE/WAIT/READY to READY), DISPATCH_PENDING (FREE/WAIT/READY to WAIT), LAST_WAKE (WAIT to READY, when the completion clears the last pending source), PARTIAL_WAKE (WAIT to WAIT) and SQUASH (WAIT/READY to FREE). A dispatch to a slot takes priority over a squash of the same slot in the same cycle.

Top module: `rsb_wakeup_unit`

## Requirements
- R1: After reset every bit of `entry_ready` is 0, `wake_count` is 0 and every scoreboard bit is not-ready, so a source dispatched as not-ready with an in-range tag keeps its slot out of READY.
- R2: A dispatch whose used sources are all flagged ready (`disp_src_rdy[k]`=1) or unused (`disp_src_vld[k]`=0) sets `entry_ready[disp_idx]` on the next cycle.
- R3: A source dispatched as not-ready whose scoreboard bit is already set counts as ready at once; no dependency is kept for it.
- R4: A dispatch with `disp_dst_vld`=1 and an in-range tag clears that tag's scoreboard bit; if a completion names the same tag in the same cycle, the clear wins.
- R5: Tags at or above NPHYS (= N_INT_REG + N_FP_REG) bypass tracking: such a source counts as ready, such a destination changes no scoreboard bit, and a completion of such a tag wakes nothing (`wake_count`=0).
- R6: A completion (`cmpl_valid`=1) of an in-range tag marks ready every pending operand that names it, and the slot's `entry_ready` bit rises on the next cycle once no operand is pending; the tag's scoreboard bit is set from the next cycle.
- R7: A slot with two pending sources stays out of READY until both tags have completed, in either order.
- R8: A slot whose bit is set in `squash_mask` is freed: its `entry_ready` bit is 0 on the next cycle and a later completion of its tags does not wake it.
- R9: A completion and a dispatch that name the same source tag in the same cycle forward: the dispatched slot sees that operand as ready.
- R10: `wake_count` is, in the same cycle as the completion, the number of slots that had at least one pending operand woken; a slot with both sources woken counts once, and it is 0 when `cmpl_valid`=0.
- R11: A dispatch and a squash that name the same slot in the same cycle leave the newly dispatched instruction in the slot.
- Source k occupies bits `[k*TAG_W +: TAG_W]` of `disp_src_tag`; slot i is bit i of `entry_ready` and `squash_mask`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch writes a slot this cycle |
| disp_idx | input | IDX_W | Slot written by dispatch |
| disp_src_vld | input | NSRC | Source k is used |
| disp_src_tag | input | NSRC*TAG_W | Source tags, source k at bits k*TAG_W |
| disp_src_rdy | input | NSRC | Rename-stage ready flag per source |
| disp_dst_vld | input | 1 | Dispatched instruction writes a register |
| disp_dst_tag | input | TAG_W | Destination tag |
| cmpl_valid | input | 1 | A destination register completed |
| cmpl_tag | input | TAG_W | Tag of the completed register |
| squash_mask | input | N_ENTRY | Slots to free |
| entry_ready | output | N_ENTRY | Slot holds an instruction with all sources ready |
| wake_count | output | CNT_W | Slots woken by this cycle's completion |

## Verification
The checker watches every cycle that a completion of an out-of-range tag, or no completion at all, reports zero woken slots, that a squashed slot never shows ready on the following cycle, that a slot dispatched with all sources flagged ready is ready on the next cycle, and that no ready bit rises in a cycle with neither dispatch nor completion. The bench's scenarios are needed for the behaviours that depend on history: the scoreboard re-check at dispatch, the clear-over-set priority on a shared tag, same-cycle forwarding, the two-source ordering, and the exact woken-slot counts when several slots share a tag.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

    localparam int NSRC = 2;

    typedef enum logic [1:0] {
        ENT_FREE = 2'd0,
        ENT_WAIT = 2'd1,
        ENT_RDY  = 2'd2
    } ent_state_e;

endpackage

// File: rtl/rsb_scoreboard.sv
module rsb_scoreboard
    import rsb_pkg::*;
#(
    parameter int NPHYS = 48,
    parameter int TAG_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   set_en,
    input  logic [TAG_W-1:0]       set_tag,
    input  logic                   clr_en,
    input  logic [TAG_W-1:0]       clr_tag,
    input  logic [NSRC*TAG_W-1:0]  look_tag,
    output logic [NSRC-1:0]        look_hit
);

    logic [NPHYS-1:0] bits_q;

    // One storage bit per physical register; clearing by a new producer
    // takes priority over a completion of the same tag.
    for (genvar r = 0; r < NPHYS; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bits_q[r] <= 1'b0;
            end else if (clr_en && clr_tag == TAG_W'(r)) begin
                bits_q[r] <= 1'b0;
            end else if (set_en && set_tag == TAG_W'(r)) begin
                bits_q[r] <= 1'b1;
            end
        end
    end

    // Lookup with forwarding from the completion of this cycle.
    for (genvar k = 0; k < NSRC; k++) begin : g_look
        logic [TAG_W-1:0] tag;
        logic             stored;
        assign tag = look_tag[k*TAG_W +: TAG_W];
        always_comb begin
            stored = 1'b0;
            for (int r = 0; r < NPHYS; r++) begin
                if (tag == TAG_W'(r)) stored = bits_q[r];
            end
        end
        assign look_hit[k] = stored || (set_en && set_tag == tag);
    end

endmodule

// File: rtl/rsb_entry.sv
module rsb_entry
    import rsb_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [NSRC*TAG_W-1:0]  wr_tag,
    input  logic [NSRC-1:0]        wr_rdy,
    input  logic                   kill,
    input  logic                   wake_en,
    input  logic [TAG_W-1:0]       wake_tag,
    output logic                   ready,
    output logic                   woke
);

    ent_state_e               state_q, state_d;
    logic [NSRC*TAG_W-1:0]    tag_q;
    logic [NSRC-1:0]          pend_q, pend_d;
    logic [NSRC-1:0]          match;

    for (genvar k = 0; k < NSRC; k++) begin : g_match
        assign match[k] = wake_en && pend_q[k] &&
                          (tag_q[k*TAG_W +: TAG_W] == wake_tag);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENT_FREE;
            pend_q  <= '0;
            tag_q   <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            if (wr_en) tag_q <= wr_tag;
        end
    end

    // Next state: dispatch first, then squash, then wakeup.
    always_comb begin
        state_d = state_q;
        pend_d  = pend_q;
        if (wr_en) begin
            pend_d  = ~wr_rdy;
            state_d = (&wr_rdy) ? ENT_RDY : ENT_WAIT;
        end else if (kill) begin
            pend_d  = '0;
            state_d = ENT_FREE;
        end else begin
            unique case (state_q)
                ENT_FREE: begin
                    pend_d = '0;
                end
                ENT_WAIT: begin
                    pend_d = pend_q & ~match;
                    if ((pend_q & ~match) == '0) state_d = ENT_RDY;
                end
                ENT_RDY: begin
                    pend_d = '0;
                end
                default: begin
                    pend_d  = '0;
                    state_d = ENT_FREE;
                end
            endcase
        end
    end

    // Outputs.
    always_comb begin
        ready = (state_q == ENT_RDY);
        woke  = (state_q == ENT_WAIT) && (|match) && !wr_en && !kill;
    end

endmodule

// File: rtl/rsb_wake_count.sv
module rsb_wake_count #(
    parameter int N     = 16,
    parameter int CNT_W = 5
) (
    input  logic [N-1:0]     hits,
    output logic [CNT_W-1:0] count
);

    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++) begin
            count = count + CNT_W'(hits[i]);
        end
    end

endmodule

// File: rtl/rsb_wakeup_unit.sv
module rsb_wakeup_unit
    import rsb_pkg::*;
#(
    parameter int N_ENTRY   = 16,
    parameter int N_INT_REG = 24,
    parameter int N_FP_REG  = 24,
    parameter int TAG_W     = 6,
    localparam int NPHYS    = N_INT_REG + N_FP_REG,
    localparam int IDX_W    = $clog2(N_ENTRY),
    localparam int CNT_W    = $clog2(N_ENTRY + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   disp_valid,
    input  logic [IDX_W-1:0]       disp_idx,
    input  logic [NSRC-1:0]        disp_src_vld,
    input  logic [NSRC*TAG_W-1:0]  disp_src_tag,
    input  logic [NSRC-1:0]        disp_src_rdy,
    input  logic                   disp_dst_vld,
    input  logic [TAG_W-1:0]       disp_dst_tag,
    input  logic                   cmpl_valid,
    input  logic [TAG_W-1:0]       cmpl_tag,
    input  logic [N_ENTRY-1:0]     squash_mask,
    output logic [N_ENTRY-1:0]     entry_ready,
    output logic [CNT_W-1:0]       wake_count
);

    localparam logic [TAG_W:0] LIMIT = (TAG_W+1)'(NPHYS);

    logic                 cmpl_in;
    logic                 dst_in;
    logic [NSRC-1:0]      src_in;
    logic [NSRC-1:0]      sb_hit;
    logic [NSRC-1:0]      src_ok;
    logic [N_ENTRY-1:0]   woke_vec;

    assign cmpl_in = cmpl_valid && ({1'b0, cmpl_tag} < LIMIT);
    assign dst_in  = disp_valid && disp_dst_vld && ({1'b0, disp_dst_tag} < LIMIT);

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        assign src_in[k] = {1'b0, disp_src_tag[k*TAG_W +: TAG_W]} < LIMIT;
        // Unused, flagged ready, untracked, or already produced.
        assign src_ok[k] = !disp_src_vld[k] || disp_src_rdy[k] ||
                           !src_in[k] || sb_hit[k];
    end

    rsb_scoreboard #(
        .NPHYS (NPHYS),
        .TAG_W (TAG_W)
    ) u_sb (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (cmpl_in),
        .set_tag  (cmpl_tag),
        .clr_en   (dst_in),
        .clr_tag  (disp_dst_tag),
        .look_tag (disp_src_tag),
        .look_hit (sb_hit)
    );

    for (genvar i = 0; i < N_ENTRY; i++) begin : g_ent
        rsb_entry #(
            .TAG_W (TAG_W)
        ) u_ent (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (disp_valid && disp_idx == IDX_W'(i)),
            .wr_tag   (disp_src_tag),
            .wr_rdy   (src_ok),
            .kill     (squash_mask[i]),
            .wake_en  (cmpl_in),
            .wake_tag (cmpl_tag),
            .ready    (entry_ready[i]),
            .woke     (woke_vec[i])
        );
    end

    rsb_wake_count #(
        .N     (N_ENTRY),
        .CNT_W (CNT_W)
    ) u_cnt (
        .hits  (woke_vec),
        .count (wake_count)
    );

endmodule

// File: rtl/rsb_checker.sv
module rsb_checker
    import rsb_pkg::*;
#(
    parameter int N_ENTRY = 16,
    parameter int NPHYS   = 48,
    parameter int TAG_W   = 6,
    parameter int IDX_W   = 4,
    parameter int CNT_W   = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   disp_valid,
    input logic [IDX_W-1:0]       disp_idx,
    input logic [NSRC-1:0]        disp_src_vld,
    input logic [NSRC*TAG_W-1:0]  disp_src_tag,
    input logic [NSRC-1:0]        disp_src_rdy,
    input logic                   disp_dst_vld,
    input logic [TAG_W-1:0]       disp_dst_tag,
    input logic                   cmpl_valid,
    input logic [TAG_W-1:0]       cmpl_tag,
    input logic [N_ENTRY-1:0]     squash_mask,
    input logic [N_ENTRY-1:0]     entry_ready,
    input logic [CNT_W-1:0]       wake_count
);

    logic [N_ENTRY-1:0] disp_hot;
    logic [N_ENTRY-1:0] kill_only;
    assign disp_hot  = disp_valid ? (N_ENTRY'(1) << disp_idx) : '0;
    assign kill_only = squash_mask & ~disp_hot;

    // R10: nothing is woken without a completion.
    assert_no_wake_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmpl_valid |-> wake_count == '0);

    // R5: an untracked tag wakes nothing.
    assert_untracked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmpl_valid && {1'b0, cmpl_tag} >= (TAG_W+1)'(NPHYS)) |-> wake_count == '0);

    // R8: a squashed slot is not ready on the next cycle.
    assert_squash_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_only != '0) |=> (entry_ready & $past(kill_only)) == '0);

    // R2: all sources flagged ready gives a ready slot next cycle.
    assert_dispatch_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && &(disp_src_rdy | ~disp_src_vld)) |=> entry_ready[$past(disp_idx)]);

    // R6: a ready bit rises only through a dispatch or a completion.
    assert_ready_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmpl_valid && !disp_valid) |=> (entry_ready & ~$past(entry_ready)) == '0);

endmodule

bind rsb_wakeup_unit rsb_checker #(
    .N_ENTRY (N_ENTRY),
    .NPHYS   (NPHYS),
    .TAG_W   (TAG_W),
    .IDX_W   (IDX_W),
    .CNT_W   (CNT_W)
) u_rsb_checker (.*);

// File: tb/tb_rsb_wakeup_unit.sv
module tb_rsb_wakeup_unit;

    localparam int N_ENTRY = 16;
    localparam int TAG_W   = 6;
    localparam int IDX_W   = 4;
    localparam int CNT_W   = 5;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  disp_valid = 1'b0;
    logic [IDX_W-1:0]      disp_idx = '0;
    logic [1:0]            disp_src_vld = '0;
    logic [2*TAG_W-1:0]    disp_src_tag = '0;
    logic [1:0]            disp_src_rdy = '0;
    logic                  disp_dst_vld = 1'b0;
    logic [TAG_W-1:0]      disp_dst_tag = '0;
    logic                  cmpl_valid = 1'b0;
    logic [TAG_W-1:0]      cmpl_tag = '0;
    logic [N_ENTRY-1:0]    squash_mask = '0;
    logic [N_ENTRY-1:0]    entry_ready;
    logic [CNT_W-1:0]      wake_count;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rsb_wakeup_unit dut (.*);

    task automatic check_eq(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        disp_valid   = 1'b0;
        disp_src_vld = '0;
        disp_src_rdy = '0;
        disp_dst_vld = 1'b0;
        cmpl_valid   = 1'b0;
        squash_mask  = '0;
    endtask

    task automatic set_disp(int idx, bit v0, int t0, bit r0, bit v1, int t1, bit r1,
                            bit dv, int dt);
        disp_valid   = 1'b1;
        disp_idx     = IDX_W'(idx);
        disp_src_vld = {v1, v0};
        disp_src_tag = {TAG_W'(t1), TAG_W'(t0)};
        disp_src_rdy = {r1, r0};
        disp_dst_vld = dv;
        disp_dst_tag = TAG_W'(dt);
    endtask

    task automatic dispatch(int idx, bit v0, int t0, bit r0, bit v1, int t1, bit r1,
                            bit dv, int dt);
        set_disp(idx, v0, t0, r0, v1, t1, r1, dv, dt);
        tick();
        idle();
    endtask

    task automatic complete(int tag, int exp_count, string req);
        cmpl_valid = 1'b1;
        cmpl_tag   = TAG_W'(tag);
        #1;
        check_eq(req, int'(wake_count), exp_count);
        tick();
        idle();
    endtask

    task automatic clear_all();
        squash_mask = '1;
        tick();
        idle();
    endtask

    task automatic t_reset();
        check_eq("R1 ready vector", int'(entry_ready), 0);
        check_eq("R1 wake count", int'(wake_count), 0);
        dispatch(0, 1, 2, 0, 0, 0, 0, 0, 0);
        check_eq("R1 scoreboard not-ready", int'(entry_ready[0]), 0);
        clear_all();
    endtask

    task automatic t_dispatch_ready();
        dispatch(0, 1, 5, 1, 0, 0, 0, 1, 10);
        check_eq("R2 all-ready dispatch", int'(entry_ready[0]), 1);
        dispatch(1, 1, 10, 0, 0, 0, 0, 0, 0);
        check_eq("R4 dst cleared, source waits", int'(entry_ready[1]), 0);
        complete(10, 1, "R10 single wake count");
        check_eq("R6 woken slot ready", int'(entry_ready[1]), 1);
        dispatch(2, 1, 10, 0, 0, 0, 0, 0, 0);
        check_eq("R3 scoreboard recheck", int'(entry_ready[2]), 1);
        dispatch(3, 0, 0, 0, 0, 0, 0, 1, 10);
        dispatch(4, 1, 10, 0, 0, 0, 0, 0, 0);
        check_eq("R4 new producer clears bit", int'(entry_ready[4]), 0);
        clear_all();
    endtask

    task automatic t_two_sources();
        dispatch(5, 1, 20, 0, 1, 21, 0, 0, 0);
        complete(21, 1, "R10 partial wake count");
        check_eq("R7 one of two sources", int'(entry_ready[5]), 0);
        complete(20, 1, "R10 final wake count");
        check_eq("R7 both sources", int'(entry_ready[5]), 1);
        clear_all();
    endtask

    task automatic t_untracked();
        dispatch(6, 1, 50, 0, 0, 0, 0, 0, 0);
        check_eq("R5 untracked source ready", int'(entry_ready[6]), 1);
        dispatch(7, 1, 22, 0, 0, 0, 0, 0, 0);
        complete(55, 0, "R5 untracked completion count");
        check_eq("R5 untracked completion no wake", int'(entry_ready[7]), 0);
        clear_all();
    endtask

    task automatic t_squash();
        dispatch(9, 1, 30, 0, 0, 0, 0, 0, 0);
        dispatch(0, 0, 0, 0, 0, 0, 0, 0, 0);
        squash_mask = 16'h0201;
        tick();
        idle();
        check_eq("R8 squash ready slot", int'(entry_ready[0]), 0);
        complete(30, 0, "R8 squashed slot not woken");
        check_eq("R8 squashed slot stays empty", int'(entry_ready[9]), 0);
        clear_all();
    endtask

    task automatic t_forward();
        set_disp(10, 1, 31, 0, 0, 0, 0, 0, 0);
        cmpl_valid = 1'b1;
        cmpl_tag   = TAG_W'(31);
        #1;
        check_eq("R10 no waiting slot", int'(wake_count), 0);
        tick();
        idle();
        check_eq("R9 same-cycle forward", int'(entry_ready[10]), 1);
        clear_all();
    endtask

    task automatic t_multi_wake();
        dispatch(11, 1, 35, 0, 0, 0, 0, 0, 0);
        dispatch(12, 0, 0, 0, 1, 35, 0, 0, 0);
        dispatch(13, 1, 35, 0, 1, 5, 1, 0, 0);
        dispatch(14, 1, 35, 0, 1, 35, 0, 0, 0);
        complete(35, 4, "R10 four slots woken");
        check_eq("R6 all four ready", int'(entry_ready[14:11]), 15);
        clear_all();
    endtask

    task automatic t_priorities();
        set_disp(15, 1, 5, 1, 0, 0, 0, 0, 0);
        squash_mask = 16'h8000;
        tick();
        idle();
        check_eq("R11 dispatch beats squash", int'(entry_ready[15]), 1);
        set_disp(1, 0, 0, 0, 0, 0, 0, 1, 40);
        cmpl_valid = 1'b1;
        cmpl_tag   = TAG_W'(40);
        tick();
        idle();
        dispatch(2, 1, 40, 0, 0, 0, 0, 0, 0);
        check_eq("R4 clear beats completion", int'(entry_ready[2]), 0);
        clear_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dispatch_ready();
        t_two_sources();
        t_untracked();
        t_squash();
        t_forward();
        t_multi_wake();
        t_priorities();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule